// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM. The host issues one request at a time: a read or a write of a single byte at a 19-bit address. The controller turns each request into the RAM's strobe sequence. It drives the address, an active-low chip select, an active-low write strobe, an active-low output enable and a shared tri-state data bus. When a transaction completes it pulses done, and for a read it presents the fetched byte on rdata.

Each phase of a sequence lasts a whole number of clock cycles, set by parameters. Each parameter is a RAM timing limit divided by the clock period and rounded up. A write lowers chip select and write strobe on the same edge and keeps output enable high, so the RAM never drives the bus during a write. The write data stays on the bus for one extra cycle after the strobes rise. A read first selects the RAM with the bus released, then lowers output enable one cycle later. After a read, a short gap with the RAM deselected lets the RAM's drivers turn off before the host may start another transaction. Between transactions the RAM is deselected.

Top module: `asram_ctl`

## Requirements
- R1: While rst is high and in the first cycle after it, sram_cs_n, sram_we_n and sram_oe_n are 1, ready is 1 and done is 0.
- R2: While no transaction is in progress, sram_cs_n, sram_we_n and sram_oe_n stay 1.
- R3: A write is accepted at a clock edge where req=1, we=1 and ready=1. From that edge, sram_cs_n and sram_we_n are both 0 for exactly WR_LEN cycles, where WR_LEN = max(WP_CYC, AWH_CYC, DS_CYC) (5 with the defaults). During those cycles sram_addr and sram_dq carry the accepted address and data.
- R4: sram_we_n is never 0 while sram_cs_n is 1 or while sram_oe_n is 0. sram_oe_n is 0 only while sram_cs_n is 0, and the controller never drives sram_dq while sram_oe_n is 0.
- R5: In the cycle after sram_we_n rises, sram_cs_n is 1 and the controller still drives the write data on sram_dq. In the cycle after that it releases the bus.
- R6: A read is accepted at an edge where req=1, we=0 and ready=1. In the next cycle sram_cs_n=0, sram_oe_n=1 and sram_we_n=1, with the address on sram_addr. sram_oe_n is then 0 for exactly RD_LEN cycles, where RD_LEN = max(RD_CYC-1, OE_CYC) (5 with the defaults). sram_addr stays stable while sram_cs_n is 0.
- R7: rdata takes the value on sram_dq in the last cycle that sram_oe_n is 0. It changes only at the end of a read and holds that value across later writes.
- R8: done is a one-cycle pulse. When the host samples on the falling edges after the drive cycle, done is first seen WR_LEN+2 falling edges after the write was driven, and RD_LEN+2 falling edges after the read was driven.
- R9: ready is 0 from acceptance until the transaction ends. After a write, ready returns in the done cycle. After a read, ready returns GAP_CYC cycles after the done cycle (2 with the defaults).
- R10: The address, data and direction are taken at acceptance. Changes on addr, wdata, we or req while ready is 0 have no effect on the RAM bus and start no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (19) | Host byte address |
| wdata | input | DATA_W (8) | Host write data |
| ready | output | 1 | Controller can accept a request |
| rdata | output | DATA_W (8) | Last read result |
| done | output | 1 | One-cycle completion pulse |
| sram_addr | output | ADDR_W (19) | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq | inout | DATA_W (8) | RAM data bus |

## Verification
A walking-one sweep over all 19 address bits shows that each address line reaches the RAM on its own, with no aliasing. A sweep of all 256 byte values, each at its own scattered address, separates data-path bit faults from address faults. Write-then-read, read-then-read and read-then-write pairs, issued back to back, test the turnaround and the gap after a read. The bench's RAM model returns the inverted byte until the read window's last cycle, so a capture one cycle early shows up as a wrong rdata. Changing the host inputs in the middle of a transaction shows whether the controller ignores them.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_TURN  = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_RD_GAP   = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Bus strobes belonging to each sequencer state.
    function automatic strobe_t strobes_of(input seq_state_e s);
        strobe_t r;
        r = STROBE_IDLE;
        case (s)
            ST_RD_TURN:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            ST_RD_WAIT:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            ST_WR_PULSE: r = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            ST_WR_HOLD:  r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
            default:     r = STROBE_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && $past(!load) && $past(cnt_q) == '0) |-> cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int WR_LEN  = 5,
    parameter int RD_LEN  = 5,
    parameter int GAP_LEN = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    we,
    output logic    ready,
    output logic    accept,
    output logic    capture,
    output logic    done,
    output strobe_t strb
);
    localparam int CW = cnt_width(max2(max2(WR_LEN, RD_LEN), GAP_LEN));

    seq_state_e    state_q, state_d;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    logic          done_d;

    asram_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (we) begin
                        state_d  = ST_WR_PULSE;
                        load     = 1'b1;
                        load_val = CW'(WR_LEN - 1);
                    end else begin
                        state_d = ST_RD_TURN;
                    end
                end
            end
            ST_RD_TURN: begin
                state_d  = ST_RD_WAIT;
                load     = 1'b1;
                load_val = CW'(RD_LEN - 1);
            end
            ST_RD_WAIT: begin
                if (expired) begin
                    capture  = 1'b1;
                    done_d   = 1'b1;
                    state_d  = ST_RD_GAP;
                    load     = 1'b1;
                    load_val = CW'(GAP_LEN - 1);
                end
            end
            ST_RD_GAP: begin
                if (expired) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (expired) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb    <= STROBE_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            strb    <= strobes_of(state_d);
            done    <= done_d;
        end
    end

    assign ready = (state_q == ST_IDLE);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> !strb.cs_n);
    // R4
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(!strb.we_n && !strb.oe_n));
    // R6
    oe_after_select_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.oe_n) |-> (!strb.cs_n && $past(!strb.cs_n)));
    // R9
    ready_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (strb.cs_n && strb.we_n && strb.oe_n));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (capture)
                rdata_q <= dq_in;
        end
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_q) |-> $past(capture));
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_q) |-> $past(accept));
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int WP_CYC  = 4,
    parameter int AWH_CYC = 5,
    parameter int DS_CYC  = 3,
    parameter int RD_CYC  = 6,
    parameter int OE_CYC  = 3,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int WR_LEN  = max2(max2(WP_CYC, AWH_CYC), max2(DS_CYC, 1));
    localparam int RD_LEN  = max2(max2(RD_CYC - 1, OE_CYC), 1);
    localparam int GAP_LEN = max2(GAP_CYC, 1);

    strobe_t           strb;
    logic              accept;
    logic              capture;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dq_in;

    asram_seq #(
        .WR_LEN  (WR_LEN),
        .RD_LEN  (RD_LEN),
        .GAP_LEN (GAP_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .we      (we),
        .ready   (ready),
        .accept  (accept),
        .capture (capture),
        .done    (done),
        .strb    (strb)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .addr    (addr),
        .wdata   (wdata),
        .capture (capture),
        .dq_in   (dq_in),
        .addr_q  (sram_addr),
        .wdata_q (wdata_q),
        .rdata_q (rdata)
    );

    assign sram_cs_n = strb.cs_n;
    assign sram_we_n = strb.we_n;
    assign sram_oe_n = strb.oe_n;
    assign sram_dq   = strb.drive ? wdata_q : {DATA_W{1'bz}};
    assign dq_in     = sram_dq;

    // Checker counters for strobe widths.
    logic [15:0] we_low_cycles;
    logic [15:0] oe_low_cycles;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cycles <= '0;
            oe_low_cycles <= '0;
        end else begin
            we_low_cycles <= sram_we_n ? 16'd0 : we_low_cycles + 16'd1;
            oe_low_cycles <= sram_oe_n ? 16'd0 : oe_low_cycles + 16'd1;
        end
    end

    // R3
    write_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_cycles == 16'(WR_LEN)));
    // R6
    read_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (oe_low_cycles == 16'(RD_LEN)));
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (strb.drive && sram_cs_n));
    // R5
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.drive && sram_we_n) |=> !strb.drive);
    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        strb.drive |-> sram_oe_n);
    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
endmodule

// File: tb/asram_ctl_test.sv
`timescale 1ns/1ps
module asram_ctl_test;
    localparam int AW     = 19;
    localparam int DW     = 8;
    localparam int WR_LEN = 5;   // max(4,5,3)
    localparam int RD_LEN = 5;   // max(6-1,3)
    localparam int GAP    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_oe_n;
    wire  [DW-1:0] sram_dq;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    asram_ctl uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .done(done), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq(sram_dq)
    );

    // RAM model
    logic [DW-1:0] mem [int];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] ram_out = '0;
    logic          ram_drive;
    assign ram_drive = !sram_cs_n && sram_we_n && !sram_oe_n;
    assign sram_dq = ram_drive ? ram_out : 8'hzz;

    int we_run = 0, oe_run = 0;
    int viol = 0, pulse_err = 0, hold_err = 0, oe_err = 0, ram_writes = 0;
    logic          hold_pending = 1'b0;
    logic [DW-1:0] wd_last = '0;
    logic [AW-1:0] wa_last = '0;

    always @(negedge clk) begin
        logic [DW-1:0] v;
        if (!rst) begin
            if (hold_pending) begin
                if (!sram_cs_n || sram_dq !== wd_last) hold_err++;
                hold_pending = 1'b0;
            end
            if (!sram_we_n) begin
                we_run++;
                wd_last = sram_dq;
                wa_last = sram_addr;
            end else if (we_run != 0) begin
                if (we_run != WR_LEN) pulse_err++;
                if (!sram_cs_n || sram_dq !== wd_last) hold_err++;
                mem[int'(wa_last)] = wd_last;
                ram_writes++;
                we_run = 0;
            end
            if (!sram_oe_n) oe_run++;
            else begin
                if (oe_run != 0 && oe_run != RD_LEN) oe_err++;
                oe_run = 0;
            end
            if (!sram_we_n && (sram_cs_n || !sram_oe_n)) viol++;
            if (!sram_oe_n && sram_cs_n) viol++;
            v = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
            ram_out = (oe_run >= RD_LEN) ? v : ~v;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (!ready) check("R9 ready timeout", 0, 1);
    endtask

    task automatic write_txn(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        wait_ready();
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        n = 1;
        // R10 junk while busy
        addr = ~a; wdata = ~d; we = 1'b0;
        check("R3 cs_n low", {31'd0, sram_cs_n}, 0);
        check("R3 we_n low", {31'd0, sram_we_n}, 0);
        check("R10 bus addr", {13'd0, sram_addr}, {13'd0, a});
        check("R3 bus data", {24'd0, sram_dq}, {24'd0, d});
        @(negedge clk);
        n = 2;
        req = 1'b0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        check("R8 write done latency", n, WR_LEN + 2);
        check("R9 ready after write", {31'd0, ready}, 1);
        shadow[int'(a)] = d;
    endtask

    task automatic read_txn(input logic [AW-1:0] a);
        int n;
        logic [DW-1:0] e;
        e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
        wait_ready();
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        n = 1;
        addr = ~a; we = 1'b1;
        check("R6 select first", {29'd0, sram_cs_n, sram_oe_n, sram_we_n}, 3'b011);
        check("R6 bus addr", {13'd0, sram_addr}, {13'd0, a});
        @(negedge clk);
        n = 2;
        req = 1'b0;
        check("R6 oe_n low", {31'd0, sram_oe_n}, 0);
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        check("R8 read done latency", n, RD_LEN + 2);
        check("R7 rdata", {24'd0, rdata}, {24'd0, e});
        check("R9 ready low in done", {31'd0, ready}, 0);
        while (!ready && n < 80) begin
            @(negedge clk);
            n++;
        end
        check("R9 read ready latency", n, RD_LEN + 2 + GAP);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] keep;
        int nw = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 strobes in reset", {29'd0, sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        check("R1 ready in reset", {31'd0, ready}, 1);
        check("R1 done in reset", {31'd0, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobes after reset", {29'd0, sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        // R2 idle
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 idle strobes", {29'd0, sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        end
        // walking-one address sweep
        for (int i = 0; i < AW; i++) begin
            write_txn(19'(1 << i), 8'(i * 37 + 11));
            nw++;
        end
        write_txn(19'h00000, 8'hC3); nw++;
        write_txn(19'h7FFFF, 8'h3C); nw++;
        for (int i = 0; i < AW; i++) read_txn(19'(1 << i));
        read_txn(19'h00000);
        read_txn(19'h7FFFF);
        // write then read back-to-back, data patterns
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80};
            write_txn(19'h2A5A5, pats[i]); nw++;
            read_txn(19'h2A5A5);
            read_txn(19'h2A5A5);
        end
        // read then write, then R7 hold across writes
        read_txn(19'h00004);
        keep = rdata;
        write_txn(19'h00123, 8'h9E); nw++;
        check("R7 rdata held over write", {24'd0, rdata}, {24'd0, keep});
        // exhaustive data sweep at scattered addresses
        for (int d = 0; d < 256; d++) begin
            write_txn(19'((d * 2053 + 7) & 19'h7FFFF) | 19'h40000, 8'(d)); nw++;
        end
        for (int d = 0; d < 256; d++)
            read_txn(19'((d * 2053 + 7) & 19'h7FFFF) | 19'h40000);
        repeat (4) @(negedge clk);
        check("R2 idle at end", {29'd0, sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        check("R3 write pulse widths", pulse_err, 0);
        check("R4 strobe violations", viol, 0);
        check("R5 data hold", hold_err, 0);
        check("R6 read window widths", oe_err, 0);
        check("R10 write count", ram_writes, nw);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule